// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles conditional branches for a 32-bit in-order core that keeps a condition register, a count register and a link register. Each cycle it may take one decoded branch: a 5-bit option field, a 5-bit condition-bit selector, a target kind, a link-update flag and a readiness flag for the condition register. It holds the count and link registers itself. It performs the optional count decrement, decides the outcome and picks the next fetch address.

When the condition register is not ready, the unit issues a prediction taken from the hint bit of the option field. It then tracks that prediction until the condition arrives. A wrong guess produces a single-cycle mispredict pulse with the correct address. A branch whose target comes from the link or count register is never predicted while that register is not ready. The unit raises a stall instead, and the upstream stage holds the branch on its inputs.

Top module: `brn_resolve_unit`

## Requirements
- R1: Option bit 4 = 1 skips the condition test. Otherwise the tested bit is `cr_val[br_bi]` and must equal option bit 3. The branch is taken only when both the condition test and the count test pass.
- R2: The don't-care option bits have no effect on any output. These are bit 3 when bit 4 = 1, bit 1 when bit 2 = 1, and bit 0 when the condition is ready or unused.
- R3: Option bit 2 = 0 decrements the count register by one, modulo 2^32, exactly once per issued branch. The count test uses the decremented value: bit 1 = 1 branches on zero and bit 1 = 0 branches on non-zero.
- R4: `br_kind` 0 targets `br_rel_tgt`, 1 targets the link register and 2 targets the count register; 3 acts as 0. A count target is the decremented value when a decrement is requested. Register targets have their two low bits cleared. `br_next_pc` is the target when taken and `br_pc`+4 otherwise.
- R5: An issued branch with `br_link` = 1 writes `br_pc`+4 into the link register whether or not it is taken. A link-kind target in the same cycle uses the old value.
- R6: When the condition is needed, `cr_ready` = 0 and the count test passes, `br_predicted` = 1 and `br_taken` equals option bit 0. Otherwise `br_predicted` = 0.
- R7: A link- or count-kind branch with `tgt_ready` = 0 stalls. It is not done and not predicted, and it changes neither register.
- R8: While a prediction is outstanding, every new branch stalls. The prediction resolves in the first cycle with `cr_ready` = 1.
- R9: On resolution, a wrong prediction gives `mispredict` = 1 for one cycle, with `fix_pc` set to the right address. A correct prediction gives no pulse.
- R10: `ctr_ld` and `lr_ld` load their register and take priority over any branch update in the same cycle.
- R11: After reset both registers read zero and no prediction is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch is presented |
| br_bo | input | 5 | Branch option field |
| br_bi | input | 5 | Condition bit selector |
| br_kind | input | 2 | Target kind: 0 relative, 1 link, 2 count |
| br_link | input | 1 | Write return address into link register |
| br_pc | input | 32 | Address of the branch |
| br_rel_tgt | input | 32 | Precomputed relative target |
| tgt_ready | input | 1 | Link/count register value is current |
| cr_ready | input | 1 | Condition register value is current |
| cr_val | input | 32 | Condition register |
| ctr_ld | input | 1 | Load count register |
| ctr_ld_val | input | 32 | Count load value |
| lr_ld | input | 1 | Load link register |
| lr_ld_val | input | 32 | Link load value |
| br_done | output | 1 | Branch issued this cycle |
| br_taken | output | 1 | Resolved or predicted direction |
| br_predicted | output | 1 | Direction is a prediction |
| br_next_pc | output | 32 | Next fetch address |
| br_stall | output | 1 | Branch must be held |
| mispredict | output | 1 | One-cycle wrong-prediction pulse |
| fix_pc | output | 32 | Correct address on mispredict |
| ctr_q | output | 32 | Count register |
| lr_q | output | 32 | Link register |

## Verification
The assertions take for granted that a stalled branch is held unchanged on the inputs until it issues. They also assume the register load ports are not driven in the same cycle as a branch whose update a check relies on. The stimulus changes branch inputs only after `br_done` has been seen. It pulses the load ports only in cycles with no valid branch, except in the one directed case that probes load priority. Prediction cases present `cr_ready` = 0 and keep it low until the cycle chosen for resolution.

// File: rtl/brn_pkg.sv
package brn_pkg;
  typedef enum logic [1:0] {
    BK_REL = 2'd0,
    BK_LR  = 2'd1,
    BK_CTR = 2'd2,
    BK_RSV = 2'd3
  } brn_kind_e;
endpackage

// File: rtl/brn_rst_sync.sv
module brn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/brn_cond_eval.sv
module brn_cond_eval #(
  parameter int XLEN = 32
) (
  input  logic [4:0]      bo_i,
  input  logic            crbit_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic            dec_o,
  output logic [XLEN-1:0] ctr_dec_o,
  output logic            ctr_ok_o,
  output logic            cond_need_o,
  output logic            cond_ok_o
);
  logic            ctr_zero;
  logic [XLEN-1:0] ctr_eff;

  always_comb begin
    dec_o       = ~bo_i[2];
    ctr_dec_o   = ctr_i - XLEN'(1);
    ctr_eff     = dec_o ? ctr_dec_o : ctr_i;
    ctr_zero    = (ctr_eff == '0);
    ctr_ok_o    = bo_i[2] | (ctr_zero == bo_i[1]);
    cond_need_o = ~bo_i[4];
    cond_ok_o   = bo_i[4] | (crbit_i == bo_i[3]);
  end
endmodule

// File: rtl/brn_pred_track.sv
module brn_pred_track #(
  parameter int XLEN = 32,
  parameter int CR_W = 32,
  parameter int BI_W = $clog2(CR_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            pred_i,
  input  logic [BI_W-1:0] bi_i,
  input  logic            want_i,
  input  logic [XLEN-1:0] tgt_i,
  input  logic [XLEN-1:0] fall_i,
  input  logic            cr_ready_i,
  input  logic [CR_W-1:0] cr_val_i,
  output logic            pend_o,
  output logic            mispredict_o,
  output logic [XLEN-1:0] fix_pc_o
);
  logic            pend_q, pend_d;
  logic            pred_q;
  logic [BI_W-1:0] bi_q;
  logic            want_q;
  logic [XLEN-1:0] tgt_q, fall_q;
  logic            resolve, actual;

  always_comb begin
    resolve      = pend_q & cr_ready_i;
    actual       = (cr_val_i[bi_q] == want_q);
    mispredict_o = resolve & (actual != pred_q);
    fix_pc_o     = actual ? tgt_q : fall_q;
    pend_d       = pend_q;
    if (start_i)      pend_d = 1'b1;
    else if (resolve) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= 1'b0;
      bi_q   <= '0;
      want_q <= 1'b0;
      tgt_q  <= '0;
      fall_q <= '0;
    end else if (start_i) begin
      pred_q <= pred_i;
      bi_q   <= bi_i;
      want_q <= want_i;
      tgt_q  <= tgt_i;
      fall_q <= fall_i;
    end
  end

  assign pend_o = pend_q;

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !pend_q);
  // R9
  mispredict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict_o |=> !mispredict_o);
endmodule

// File: rtl/brn_resolve_unit.sv
module brn_resolve_unit #(
  parameter int XLEN = 32,
  parameter int CR_W = 32,
  parameter int BI_W = $clog2(CR_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [4:0]      br_bo,
  input  logic [BI_W-1:0] br_bi,
  input  logic [1:0]      br_kind,
  input  logic            br_link,
  input  logic [XLEN-1:0] br_pc,
  input  logic [XLEN-1:0] br_rel_tgt,
  input  logic            tgt_ready,
  input  logic            cr_ready,
  input  logic [CR_W-1:0] cr_val,
  input  logic            ctr_ld,
  input  logic [XLEN-1:0] ctr_ld_val,
  input  logic            lr_ld,
  input  logic [XLEN-1:0] lr_ld_val,
  output logic            br_done,
  output logic            br_taken,
  output logic            br_predicted,
  output logic [XLEN-1:0] br_next_pc,
  output logic            br_stall,
  output logic            mispredict,
  output logic [XLEN-1:0] fix_pc,
  output logic [XLEN-1:0] ctr_q,
  output logic [XLEN-1:0] lr_q
);
  import brn_pkg::*;

  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);
  localparam logic [XLEN-1:0] ILEN       = XLEN'(4);

  logic            rst_n_s;
  brn_kind_e       kind;
  logic            reg_kind;
  logic            dec_req, ctr_ok, cond_need, cond_ok;
  logic [XLEN-1:0] ctr_dec;
  logic            pend;
  logic            issue, predict, taken_dir;
  logic [XLEN-1:0] target, fall;
  logic [XLEN-1:0] ctr_d, lr_d;
  logic            ctr_en, lr_en;

  brn_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  brn_cond_eval #(.XLEN(XLEN)) cond_i (
    .bo_i(br_bo), .crbit_i(cr_val[br_bi]), .ctr_i(ctr_q),
    .dec_o(dec_req), .ctr_dec_o(ctr_dec), .ctr_ok_o(ctr_ok),
    .cond_need_o(cond_need), .cond_ok_o(cond_ok)
  );

  // Decode, stall, outcome and target selection.
  always_comb begin
    kind     = brn_kind_e'(br_kind);
    reg_kind = (kind == BK_LR) || (kind == BK_CTR);
    br_stall = br_valid & (pend | (reg_kind & ~tgt_ready));
    issue    = br_valid & ~br_stall;
    predict  = issue & cond_need & ~cr_ready & ctr_ok;
    taken_dir = predict ? br_bo[0] : (ctr_ok & cond_ok);
    fall     = br_pc + ILEN;
    unique case (kind)
      BK_LR:   target = lr_q & ALIGN_MASK;
      BK_CTR:  target = (dec_req ? ctr_dec : ctr_q) & ALIGN_MASK;
      default: target = br_rel_tgt;
    endcase
    br_done      = issue;
    br_taken     = issue & taken_dir;
    br_predicted = predict;
    br_next_pc   = taken_dir ? target : fall;
  end

  brn_pred_track #(.XLEN(XLEN), .CR_W(CR_W), .BI_W(BI_W)) pred_i (
    .clk(clk), .rst_n(rst_n_s),
    .start_i(predict), .pred_i(br_bo[0]), .bi_i(br_bi), .want_i(br_bo[3]),
    .tgt_i(target), .fall_i(fall),
    .cr_ready_i(cr_ready), .cr_val_i(cr_val),
    .pend_o(pend), .mispredict_o(mispredict), .fix_pc_o(fix_pc)
  );

  // Register next-state: load port wins over branch update.
  always_comb begin
    ctr_en = ctr_ld | (issue & dec_req);
    ctr_d  = ctr_ld ? ctr_ld_val : ctr_dec;
    lr_en  = lr_ld | (issue & br_link);
    lr_d   = lr_ld ? lr_ld_val : fall;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    ctr_q <= '0;
    else if (ctr_en) ctr_q <= ctr_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   lr_q <= '0;
    else if (lr_en) lr_q <= lr_d;
  end

  // R3
  ctr_dec_once_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (br_done && !br_bo[2] && !ctr_ld) |=> (ctr_q == $past(ctr_q) - XLEN'(1)));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (br_stall && !ctr_ld && !lr_ld) |=> ($stable(ctr_q) && $stable(lr_q)));
  // R5
  link_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (br_done && br_link && !lr_ld) |=> (lr_q == $past(br_pc) + ILEN));
  // R4
  reg_tgt_align_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (br_taken && (br_kind == 2'd1 || br_kind == 2'd2)) |-> (br_next_pc[1:0] == 2'b00));
  // R6
  predict_notready_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    br_predicted |-> (!cr_ready && br_done && !br_bo[4]));
  // R7
  stall_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    br_stall |-> (!br_done && !br_predicted));
endmodule

// File: tb/brn_resolve_unit_tb_top.sv
`timescale 1ns/1ps
module brn_resolve_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid, br_link, tgt_ready, cr_ready, ctr_ld, lr_ld;
  logic [4:0]  br_bo, br_bi;
  logic [1:0]  br_kind;
  logic [31:0] br_pc, br_rel_tgt, cr_val, ctr_ld_val, lr_ld_val;
  logic        br_done, br_taken, br_predicted, br_stall, mispredict;
  logic [31:0] br_next_pc, fix_pc, ctr_q, lr_q;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  brn_resolve_unit dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_bo(br_bo), .br_bi(br_bi),
    .br_kind(br_kind), .br_link(br_link), .br_pc(br_pc), .br_rel_tgt(br_rel_tgt),
    .tgt_ready(tgt_ready), .cr_ready(cr_ready), .cr_val(cr_val),
    .ctr_ld(ctr_ld), .ctr_ld_val(ctr_ld_val), .lr_ld(lr_ld), .lr_ld_val(lr_ld_val),
    .br_done(br_done), .br_taken(br_taken), .br_predicted(br_predicted),
    .br_next_pc(br_next_pc), .br_stall(br_stall), .mispredict(mispredict),
    .fix_pc(fix_pc), .ctr_q(ctr_q), .lr_q(lr_q)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle();
    br_valid = 0; br_link = 0; ctr_ld = 0; lr_ld = 0;
    tgt_ready = 1; cr_ready = 1;
  endtask

  task automatic load_ctr(input logic [31:0] v);
    @(negedge clk); idle(); ctr_ld = 1; ctr_ld_val = v;
    @(negedge clk); ctr_ld = 0;
  endtask

  task automatic load_lr(input logic [31:0] v);
    @(negedge clk); idle(); lr_ld = 1; lr_ld_val = v;
    @(negedge clk); lr_ld = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] exp_lr;
    idle();
    br_bo = 0; br_bi = 0; br_kind = 0; br_pc = 0; br_rel_tgt = 0; cr_val = 0;
    ctr_ld_val = 0; lr_ld_val = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R11 reset state
    chk_eq("R11 ctr after reset", ctr_q, 32'h0);
    chk_eq("R11 lr after reset", lr_q, 32'h0);
    chk_eq("R11 no stall", {31'b0, br_stall}, 32'h0);
    chk_eq("R11 no mispredict", {31'b0, mispredict}, 32'h0);

    load_lr(32'h0000_5a5b);
    exp_lr = 32'h0000_5a5b;

    // Sweep: every option value, both condition values, three kinds, four counts.
    for (int bo = 0; bo < 32; bo++) begin
      for (int crb = 0; crb < 2; crb++) begin
        for (int kd = 0; kd < 3; kd++) begin
          for (int ci = 0; ci < 4; ci++) begin
            logic [31:0] c0, cnew, tgt, expn, pc, rel;
            logic [4:0]  b;
            logic        ctr_ok, cond_ok, tk, lnk;
            int          bi;
            c0  = (ci == 0) ? 32'h0 : (ci == 1) ? 32'h1 : (ci == 2) ? 32'h2 : 32'h0000_0107;
            b   = 5'(bo);
            bi  = (bo * 7 + kd + crb) % 32;
            pc  = 32'h0001_0000 + 32'(bo * 64 + kd * 16 + ci * 4);
            rel = 32'h0008_0000 + 32'(bo * 256 + crb * 8);
            lnk = b[0] ^ kd[0] ^ ci[0];
            load_ctr(c0);
            cnew    = b[2] ? c0 : c0 - 1;
            ctr_ok  = b[2] || ((cnew == 0) == b[1]);
            cond_ok = b[4] || (crb[0] == b[3]);
            tk      = ctr_ok && cond_ok;
            if (kd == 1)      tgt = exp_lr & ~32'h3;
            else if (kd == 2) tgt = cnew & ~32'h3;
            else              tgt = rel;
            expn = tk ? tgt : pc + 4;
            @(negedge clk);
            br_valid = 1; br_bo = b; br_bi = 5'(bi); br_kind = 2'(kd); br_link = lnk;
            br_pc = pc; br_rel_tgt = rel; tgt_ready = 1; cr_ready = 1;
            cr_val = crb[0] ? (32'h1 << bi) : ~(32'h1 << bi);
            #1;
            // R1 R2: outcome depends only on defined option bits
            chk_eq("R1 R2 taken", {31'b0, br_taken}, {31'b0, tk});
            // R4 target selection
            chk_eq("R4 next_pc", br_next_pc, expn);
            chk_eq("R6 no prediction when ready", {31'b0, br_predicted}, 32'h0);
            chk_eq("R7 done when ready", {31'b0, br_done}, 32'h1);
            @(negedge clk);
            idle();
            #1;
            // R3 single decrement, modulo wrap
            chk_eq("R3 ctr after branch", ctr_q, cnew);
            if (lnk) exp_lr = pc + 4;
            // R5 link write regardless of direction
            chk_eq("R5 lr after branch", lr_q, exp_lr);
          end
        end
      end
    end

    // R7: count target not ready stalls without any register change
    load_ctr(32'h5);
    @(negedge clk);
    br_valid = 1; br_bo = 5'b10000; br_bi = 0; br_kind = 2'd2; br_link = 1;
    br_pc = 32'h4000; tgt_ready = 0; cr_ready = 1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk_eq("R7 stall", {31'b0, br_stall}, 32'h1);
      chk_eq("R7 not done", {31'b0, br_done}, 32'h0);
      chk_eq("R7 not predicted", {31'b0, br_predicted}, 32'h0);
      @(negedge clk);
      #1;
      chk_eq("R7 ctr held", ctr_q, 32'h5);
    end
    tgt_ready = 1;
    #1;
    chk_eq("R7 done after ready", {31'b0, br_done}, 32'h1);
    chk_eq("R4 count target decremented", br_next_pc, 32'h4);
    @(negedge clk); idle(); #1;
    chk_eq("R3 one decrement after stall", ctr_q, 32'h4);
    chk_eq("R5 lr after stalled branch", lr_q, 32'h4004);

    // R6 R8 R9: wrong prediction
    @(negedge clk);
    br_valid = 1; br_bo = 5'b00101; br_bi = 5'd3; br_kind = 2'd0; br_link = 0;
    br_pc = 32'h3000; br_rel_tgt = 32'h2000; cr_ready = 0; cr_val = 32'h0;
    #1;
    chk_eq("R6 predicted", {31'b0, br_predicted}, 32'h1);
    chk_eq("R6 hint direction", {31'b0, br_taken}, 32'h1);
    chk_eq("R6 predicted target", br_next_pc, 32'h2000);
    @(negedge clk);
    br_bo = 5'b10100; br_pc = 32'h3100; br_rel_tgt = 32'h3200;
    #1;
    chk_eq("R8 stall while pending", {31'b0, br_stall}, 32'h1);
    chk_eq("R8 no mispredict before ready", {31'b0, mispredict}, 32'h0);
    @(negedge clk);
    cr_ready = 1; cr_val = 32'h8;
    #1;
    chk_eq("R9 mispredict pulse", {31'b0, mispredict}, 32'h1);
    chk_eq("R9 fix address", fix_pc, 32'h3004);
    @(negedge clk); #1;
    chk_eq("R9 pulse one cycle", {31'b0, mispredict}, 32'h0);
    chk_eq("R8 new branch issues", {31'b0, br_done}, 32'h1);
    chk_eq("R8 new branch target", br_next_pc, 32'h3200);

    // R9: correct prediction, not taken
    @(negedge clk);
    br_valid = 1; br_bo = 5'b00100; br_bi = 5'd7; br_kind = 2'd0;
    br_pc = 32'h5000; br_rel_tgt = 32'h6000; cr_ready = 0;
    #1;
    chk_eq("R6 predict not taken", br_next_pc, 32'h5004);
    @(negedge clk);
    br_valid = 0; cr_ready = 1; cr_val = 32'h80;
    #1;
    chk_eq("R9 correct prediction no pulse", {31'b0, mispredict}, 32'h0);

    // R6: failing count test resolves without prediction
    load_ctr(32'h1);
    @(negedge clk);
    br_valid = 1; br_bo = 5'b00001; br_bi = 0; br_kind = 2'd0; cr_ready = 0;
    br_pc = 32'h7000; br_rel_tgt = 32'h7100;
    #1;
    chk_eq("R6 no prediction when count fails", {31'b0, br_predicted}, 32'h0);
    chk_eq("R6 not taken when count fails", br_next_pc, 32'h7004);
    @(negedge clk); idle(); #1;
    chk_eq("R6 no pending after", {31'b0, br_stall}, 32'h0);

    // R10: loads win over branch updates
    @(negedge clk);
    br_valid = 1; br_bo = 5'b10000; br_kind = 2'd0; br_link = 1; br_pc = 32'h9000;
    ctr_ld = 1; ctr_ld_val = 32'hABCD_0000; lr_ld = 1; lr_ld_val = 32'h1234_5678;
    @(negedge clk); idle(); #1;
    chk_eq("R10 ctr load priority", ctr_q, 32'hABCD_0000);
    chk_eq("R10 lr load priority", lr_q, 32'h1234_5678);

    finish_run();
  end
endmodule